// File: doc/BRIEF.md
# Compensated Timestamp Counter with Capture

A free-running 64-bit time base for stamping sampled data. On every enabled clock the count advances by a programmable step. A one-shot compensation budget can trim the rate: while the budget is non-zero, a separate compensation step replaces the normal step, and the budget shrinks by one on each such cycle. Software reads the count as two 32-bit halves. Reading the low half freezes a copy of the high half, so a low-then-high read pair always gives a consistent 64-bit value.

One compare channel watches the count for equality with a 64-bit target. A match raises a sticky flag and a one-cycle event pulse, and it can optionally return the count to zero. A sticky overflow flag marks each wrap of the low 32-bit half, which lets software extend a 32-bit view in firmware. An asynchronous latch input is synchronized and edge-detected. When capture is enabled, each rising edge on this input copies the full count into a readable capture register and sets a capture-valid flag, so the count can be aligned with a pulse from another time domain.

Top module: `stamp_counter`

Register word addresses: 0 config, 1 status, 2 compensation budget, 3 count low, 4 count high, 5 compare control, 6 compare status, 7 compare low, 8 compare high, 9 capture control, 10 capture low, 11 capture high.

## Requirements
- R1: After reset the count, compare value, compensation budget, capture registers and all flags read zero, counting is off, and the config register reads 0x10 (run bit 0 = 0, step field bits 7:4 = 1, compensation step field bits 11:8 = 0).
- R2: While the run bit (config bit 0) is clear, the count holds its value.
- R3: While running with a zero compensation budget, the count grows by the step field (config bits 7:4) on each clock.
- R4: While running with a non-zero compensation budget (address 2), the count grows by the compensation step (config bits 11:8) instead, and the budget drops by one on that cycle.
- R5: Writes to the count halves (addresses 3 and 4) take effect on the next clock, and a carry out of the low half increments the high half.
- R6: Status bit 0 is a sticky flag that sets when the low half wraps past 0xFFFFFFFF. Writing 1 to that bit clears it.
- R7: When compare enable (compare control bit 0) is set and the count equals the compare value, compare status bit 0 sets (sticky, write 1 to clear) and `cmp_event` pulses for one cycle. With compare enable clear, a match has no effect.
- R8: With reset-on-match (compare control bit 1) also set, the count is zero on the cycle after a match.
- R9: With capture enable (capture control bit 0) set, a rising edge on `latch_in` copies the full count into the capture registers after the synchronizer delay. A held level, or an edge while capture is disabled, captures nothing.
- R10: A read of the count low half snapshots the high half. Later reads of the count high half return that snapshot until the next low-half read.
- R11: Status bit 1 sets on each capture and clears when the capture low half is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| latch_in | input | 1 | Asynchronous capture trigger |
| cmp_event | output | 1 | One-cycle pulse on a compare match |

## Verification
The bench builds the block with its default parameters: a 23-bit compensation budget and a two-stage synchronizer. The latch wait in the bench is derived from the synchronizer depth. Because the count halves are writable, the low-half wrap and the 64-bit carry can be reached within a few clocks instead of 2^32. Every run is a fixed number of enabled clocks with the counter stopped around it, so each expected count is exact arithmetic on step, compensation step and budget.

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int ADDR_W      = 4,
  parameter int COMP_W      = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              latch_in,
  output logic              cmp_event
);
  localparam logic [ADDR_W-1:0] A_CFG = 0, A_STAT = 1, A_COMP = 2, A_CLO = 3, A_CHI = 4,
    A_CCFG = 5, A_CSTAT = 6, A_KLO = 7, A_KHI = 8, A_LCTL = 9, A_LLO = 10, A_LHI = 11;

  logic                   run_q, ovf_q, cflag_q, cmp_en_q, rst_en_q, lat_en_q, lat_v_q, prev_q;
  logic [3:0]             dinc_q, cinc_q;
  logic [COMP_W-1:0]      comp_q;
  logic [63:0]            cnt_q, cmp_q, lat_q;
  logic [31:0]            hi_snap_q;
  logic [SYNC_STAGES-1:0] sync_q;

  wire [3:0]  step     = (comp_q != '0) ? cinc_q : dinc_q;
  wire [63:0] cnt_inc  = cnt_q + 64'(step);
  wire        lo_carry = ({1'b0, cnt_q[31:0]} + 33'(step)) > 33'hFFFF_FFFF;
  wire        hit      = cmp_en_q && (cnt_q == cmp_q);
  wire        zap      = hit && rst_en_q;
  wire        edge_det = sync_q[SYNC_STAGES-1] & ~prev_q;
  wire        capture  = edge_det && lat_en_q;

  wire w_cfg   = wr_en && addr == A_CFG;
  wire w_stat  = wr_en && addr == A_STAT;
  wire w_comp  = wr_en && addr == A_COMP;
  wire w_clo   = wr_en && addr == A_CLO;
  wire w_chi   = wr_en && addr == A_CHI;
  wire w_ccfg  = wr_en && addr == A_CCFG;
  wire w_cstat = wr_en && addr == A_CSTAT;
  wire w_klo   = wr_en && addr == A_KLO;
  wire w_khi   = wr_en && addr == A_KHI;
  wire w_lctl  = wr_en && addr == A_LCTL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; dinc_q <= 4'd1; cinc_q <= '0; comp_q <= '0;
      cnt_q <= '0; cmp_q <= '0; lat_q <= '0; hi_snap_q <= '0;
      ovf_q <= 1'b0; cflag_q <= 1'b0; cmp_en_q <= 1'b0; rst_en_q <= 1'b0;
      lat_en_q <= 1'b0; lat_v_q <= 1'b0; sync_q <= '0; prev_q <= 1'b0;
      cmp_event <= 1'b0;
    end else begin
      if (w_cfg) {cinc_q, dinc_q, run_q} <= {wdata[11:8], wdata[7:4], wdata[0]};

      if (w_comp) comp_q <= wdata[COMP_W-1:0];
      else if (run_q && comp_q != '0) comp_q <= comp_q - 1'b1;

      if (w_clo || w_chi) begin
        if (w_clo) cnt_q[31:0]  <= wdata;
        if (w_chi) cnt_q[63:32] <= wdata;
      end else if (zap) cnt_q <= '0;
      else if (run_q) cnt_q <= cnt_inc;

      if (run_q && !zap && !w_clo && !w_chi && lo_carry) ovf_q <= 1'b1;
      else if (w_stat && wdata[0]) ovf_q <= 1'b0;

      cmp_event <= hit;
      if (hit) cflag_q <= 1'b1;
      else if (w_cstat && wdata[0]) cflag_q <= 1'b0;

      if (w_ccfg) {rst_en_q, cmp_en_q} <= wdata[1:0];
      if (w_klo) cmp_q[31:0]  <= wdata;
      if (w_khi) cmp_q[63:32] <= wdata;

      sync_q <= {sync_q[SYNC_STAGES-2:0], latch_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (w_lctl) lat_en_q <= wdata[0];
      if (capture) begin
        lat_q   <= cnt_q;
        lat_v_q <= 1'b1;
      end else if (rd_en && addr == A_LLO) lat_v_q <= 1'b0;

      if (rd_en && addr == A_CLO) hi_snap_q <= cnt_q[63:32];
    end
  end

  always_comb begin
    case (addr)
      A_CFG:   rdata = {20'd0, cinc_q, dinc_q, 3'd0, run_q};
      A_STAT:  rdata = {30'd0, lat_v_q, ovf_q};
      A_COMP:  rdata = 32'(comp_q);
      A_CLO:   rdata = cnt_q[31:0];
      A_CHI:   rdata = hi_snap_q;
      A_CCFG:  rdata = {30'd0, rst_en_q, cmp_en_q};
      A_CSTAT: rdata = {31'd0, cflag_q};
      A_KLO:   rdata = cmp_q[31:0];
      A_KHI:   rdata = cmp_q[63:32];
      A_LCTL:  rdata = {31'd0, lat_en_q};
      A_LLO:   rdata = lat_q[31:0];
      A_LHI:   rdata = lat_q[63:32];
      default: rdata = '0;
    endcase
  end
endmodule

module stamp_counter_chk #(
  parameter int ADDR_W = 4,
  parameter int COMP_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit0,
  input logic              run,
  input logic [3:0]        dinc,
  input logic [COMP_W-1:0] comp,
  input logic [63:0]       cnt,
  input logic [63:0]       cmp,
  input logic              cmp_en,
  input logic              rst_en,
  input logic              ovf,
  input logic              cflag,
  input logic              lat_en,
  input logic              lat_v
);
  wire cnt_wr = wr_en && (addr == ADDR_W'(3) || addr == ADDR_W'(4));
  wire match  = cmp_en && cnt == cmp;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr && !(match && rst_en) |=> $stable(cnt));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && comp == '0 && !cnt_wr && !(match && rst_en) |=> cnt == $past(cnt) + 64'($past(dinc)));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(wr_en && addr == ADDR_W'(1) && wbit0) |=> ovf);
  // R7
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cflag);
  // R8
  rst_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match && rst_en && !cnt_wr |=> cnt == 64'd0);
  // R11
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_v) |-> $past(lat_en));
endmodule

bind stamp_counter stamp_counter_chk #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .run(run_q), .dinc(dinc_q), .comp(comp_q), .cnt(cnt_q), .cmp(cmp_q),
  .cmp_en(cmp_en_q), .rst_en(rst_en_q), .ovf(ovf_q), .cflag(cflag_q),
  .lat_en(lat_en_q), .lat_v(lat_v_q));

// File: tb/stamp_counter_test.sv
`timescale 1ns/1ps
module stamp_counter_test;
  localparam int ADDR_W = 4, COMP_W = 23, SYNC_STAGES = 2;
  localparam logic [3:0] A_CFG = 0, A_STAT = 1, A_COMP = 2, A_CLO = 3, A_CHI = 4,
    A_CCFG = 5, A_CSTAT = 6, A_KLO = 7, A_KHI = 8, A_LCTL = 9, A_LLO = 10, A_LHI = 11;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, latch_in = 0, cmp_event;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0, ev_cnt = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  stamp_counter #(.ADDR_W(ADDR_W), .COMP_W(COMP_W), .SYNC_STAGES(SYNC_STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .latch_in(latch_in), .cmp_event(cmp_event));

  always @(negedge clk) begin
    if (cmp_event) ev_cnt++;
    if (rd_en && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdata, e);
      end
    end
  end

  function automatic logic [31:0] cfgv(logic en, logic [3:0] di, logic [3:0] ci);
    return {20'd0, ci, di, 3'd0, en};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] e, string t);
    rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run(int n, logic [3:0] di, logic [3:0] ci);
    wr(A_CFG, cfgv(1, di, ci));
    idle(n - 1);
    wr(A_CFG, cfgv(0, di, ci));
  endtask

  task automatic direct(logic [31:0] got, logic [31:0] e, string t);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", t, got, e);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(A_CFG, 32'h10, "R1 cfg");
    rd(A_CLO, 0, "R1 cnt lo");
    rd(A_CHI, 0, "R1 cnt hi");
    rd(A_STAT, 0, "R1 status");
    rd(A_COMP, 0, "R1 budget");
    rd(A_CSTAT, 0, "R1 cmp status");
    rd(A_KLO, 0, "R1 cmp lo");
    rd(A_LLO, 0, "R1 capture lo");
    rd(A_LCTL, 0, "R1 capture ctl");
    // R3 default step
    wr(A_CFG, cfgv(0, 3, 0));
    run(7, 3, 0);
    rd(A_CLO, 21, "R3 step 3 x7");
    // R2 hold while stopped
    idle(10);
    rd(A_CLO, 21, "R2 hold");
    // R4 compensation
    wr(A_CLO, 0);
    wr(A_COMP, 3);
    run(5, 2, 4);
    rd(A_CLO, 16, "R4 budget used up");
    rd(A_COMP, 0, "R4 budget zero");
    wr(A_COMP, 10);
    run(4, 2, 4);
    rd(A_CLO, 32, "R4 partial budget");
    rd(A_COMP, 6, "R4 budget left");
    wr(A_COMP, 0);
    // R5 R6 R10 wrap and carry
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 0);
    run(3, 1, 0);
    rd(A_CLO, 1, "R5 low after wrap");
    rd(A_CHI, 1, "R5 carry into high");
    rd(A_STAT, 1, "R6 overflow set");
    idle(3);
    rd(A_STAT, 1, "R6 overflow sticky");
    wr(A_STAT, 1);
    rd(A_STAT, 0, "R6 overflow cleared");
    wr(A_CHI, 5);
    rd(A_CHI, 1, "R10 snapshot kept");
    rd(A_CLO, 1, "R10 low");
    rd(A_CHI, 5, "R10 new snapshot");
    // R7 compare
    wr(A_CHI, 0);
    wr(A_CLO, 0);
    wr(A_KLO, 10);
    wr(A_KHI, 0);
    run(15, 1, 0);
    rd(A_CSTAT, 0, "R7 disabled compare ignored");
    direct(ev_cnt, 0, "R7 no event when disabled");
    wr(A_CCFG, 1);
    wr(A_CLO, 0);
    run(15, 1, 0);
    rd(A_CLO, 15, "R7 no reset without rst enable");
    rd(A_CSTAT, 1, "R7 compare flag");
    direct(ev_cnt, 1, "R7 single event pulse");
    wr(A_CSTAT, 1);
    rd(A_CSTAT, 0, "R7 compare flag cleared");
    // R8 reset on match
    wr(A_CCFG, 3);
    wr(A_CLO, 0);
    run(15, 1, 0);
    rd(A_CLO, 4, "R8 count restarted at match");
    rd(A_CSTAT, 1, "R8 flag on match");
    wr(A_CCFG, 0);
    wr(A_CSTAT, 1);
    // R9 R11 capture
    wr(A_CLO, 32'h9ABC_DEF0);
    wr(A_CHI, 32'h1234_5678);
    wr(A_LCTL, 1);
    latch_in = 1;
    idle(SYNC_STAGES + 3);
    rd(A_STAT, 2, "R11 capture valid");
    rd(A_LLO, 32'h9ABC_DEF0, "R9 capture lo");
    rd(A_LHI, 32'h1234_5678, "R9 capture hi");
    rd(A_STAT, 0, "R11 valid cleared by read");
    latch_in = 0;
    idle(5);
    wr(A_LCTL, 0);
    wr(A_CLO, 32'h11);
    latch_in = 1;
    idle(SYNC_STAGES + 4);
    rd(A_LLO, 32'h9ABC_DEF0, "R9 edge ignored while disabled");
    rd(A_STAT, 0, "R9 no valid while disabled");
    wr(A_LCTL, 1);
    idle(SYNC_STAGES + 4);
    rd(A_LLO, 32'h9ABC_DEF0, "R9 held level no capture");
    rd(A_STAT, 0, "R11 held level no valid");
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule